// File: doc/BRIEF.md
# Segmented Page-Table Entry Address Generator

When a virtual-to-physical translation misses, the walker needs to know which memory word holds the page-table entry for the faulting page. This block works that out. Each segment of the virtual space has its own linear page table, which is described by a base register holding a physical address and a bound register holding an entry count. The two most significant address bits select the segment. The next eighteen bits give the page number. The low twelve bits are the offset within a 4 KB page and play no part in the calculation.

A request carries one 32-bit virtual address on a valid/ready handshake. The block checks the request in a fixed order. First it checks that the segment is in use, then that the page number lies below that segment's bound. If both checks pass, it forms the entry address as the base plus four times the page number. The result is registered and appears one cycle after acceptance as either an entry address or a fault code. It stays on the outputs until the consumer takes it. The base and bound registers are loaded through a small write port.

Top module: `pte_addr_gen`

## Requirements
- R1: After a synchronous active-high reset, `rsp_valid` is 0, `req_ready` is 1, and every base and bound register is 0. Any request to a segment in use therefore returns a bounds fault until its bound is written.
- R2: Bits 31:30 of `req_va` select the segment and bits 29:12 give the page number. Bits 11:0 have no effect on the response.
- R3: For a request that passes both checks, `rsp_fault` is 0 and `rsp_addr` equals base[segment] + 4 × page number, taken modulo 2^32.
- R4: A request whose segment field is 00 returns `rsp_fault` = 1 and `rsp_addr` = 0, whatever values the registers hold.
- R5: A request to segment 01, 10 or 11 whose page number is greater than or equal to that segment's bound returns `rsp_fault` = 2 and `rsp_addr` = 0. A page number of bound − 1 is accepted.
- R6: When `cfg_we` is 1, `cfg_sel[1:0]` names the segment and `cfg_sel[2]` picks the register: 0 for base, which takes all 32 bits of `cfg_data`, and 1 for bound, which takes `cfg_data[17:0]`. Writes that name segment 00 are discarded.
- R7: A request is accepted on a rising edge where both `req_valid` and `req_ready` are 1. Its response is presented with `rsp_valid` = 1 from the next cycle on. `req_ready` equals `!rsp_valid || rsp_ready`.
- R8: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_fault` and `rsp_addr` hold their values.
- R9: A register write in the same cycle as an accepted request does not affect that request's response. It applies only to requests accepted in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Bit 2: 0 selects base, 1 selects bound; bits 1:0 select the segment |
| cfg_data | input | 32 | Write data |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address that missed |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_fault | output | 2 | 0 none, 1 segment unused, 2 beyond bound |
| rsp_addr | output | 32 | Physical address of the entry (0 on a fault) |

## Verification
The bench targets the bound edge: it checks page numbers equal to bound − 1 and equal to bound. A design that compares with the wrong inequality either faults a legal last entry or passes one entry past the end of the table. It also checks that the sum wraps at 2^32, that offset bits are ignored, and that writes naming segment 00 are discarded. Getting any of these wrong would show up as a corrupted entry address or a segment-00 request that escapes its fault. Response stalls with `rsp_ready` low, and register writes that land in the same cycle as a request, are compared against a running model on every clock. A design that loses or overwrites a held response, or uses a freshly written bound too early, therefore diverges at once.

// File: rtl/pte_gen_pkg.sv
package pte_gen_pkg;

    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int SEG_W     = 2;
    localparam int VPN_W     = VA_W - SEG_W - OFF_W;
    localparam int PA_W      = 32;
    localparam int PTE_SHIFT = 2;
    localparam int NSEG      = 1 << SEG_W;
    localparam int CFG_W     = SEG_W + 1;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_SEG   = 2'd1,
        FLT_BOUND = 2'd2
    } fault_e;

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        logic [VPN_W-1:0] vpn;
        logic [OFF_W-1:0] off;
    } va_t;

    typedef struct packed {
        fault_e          fault;
        logic [PA_W-1:0] addr;
    } rsp_t;

    function automatic logic [PA_W-1:0] scale_vpn(input logic [VPN_W-1:0] v);
        return PA_W'(v) << PTE_SHIFT;
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import pte_gen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_sel,
    input  logic [PA_W-1:0]  cfg_data,
    input  logic [SEG_W-1:0] rd_seg,
    output logic [PA_W-1:0]  rd_base,
    output logic [VPN_W-1:0] rd_bound
);

    logic [PA_W-1:0]  base_q  [NSEG];
    logic [VPN_W-1:0] bound_q [NSEG];

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        if (s == 0) begin : g_unused
            assign base_q[s]  = '0;
            assign bound_q[s] = '0;
        end else begin : g_live
            logic hit;
            assign hit = cfg_we && (cfg_sel[SEG_W-1:0] == SEG_W'(s));
            always_ff @(posedge clk) begin
                if (rst) begin
                    base_q[s]  <= '0;
                    bound_q[s] <= '0;
                end else if (hit) begin
                    if (cfg_sel[SEG_W])
                        bound_q[s] <= cfg_data[VPN_W-1:0];
                    else
                        base_q[s]  <= cfg_data;
                end
            end
        end
    end

    assign rd_base  = base_q[rd_seg];
    assign rd_bound = bound_q[rd_seg];

endmodule

// File: rtl/pte_calc.sv
module pte_calc
    import pte_gen_pkg::*;
(
    input  va_t              va,
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] bound,
    output rsp_t             res
);

    always_comb begin
        res.fault = FLT_NONE;
        res.addr  = '0;
        if (va.seg == '0) begin
            res.fault = FLT_SEG;
        end else if (va.vpn >= bound) begin
            res.fault = FLT_BOUND;
        end else begin
            res.addr = base + scale_vpn(va.vpn);
        end
    end

endmodule

// File: rtl/pte_addr_gen.sv
module pte_addr_gen
    import pte_gen_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_sel,
    input  logic [31:0] cfg_data,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_va,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [1:0]  rsp_fault,
    output logic [31:0] rsp_addr
);

    va_t              va;
    logic [PA_W-1:0]  seg_base;
    logic [VPN_W-1:0] seg_bound;
    rsp_t             calc_res;
    rsp_t             rsp_q;
    logic             valid_q;
    logic             accept;

    assign va        = va_t'(req_va);
    assign req_ready = !valid_q || rsp_ready;
    assign accept    = req_valid && req_ready;

    seg_table u_table (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .rd_seg   (va.seg),
        .rd_base  (seg_base),
        .rd_bound (seg_bound)
    );

    pte_calc u_calc (
        .va    (va),
        .base  (seg_base),
        .bound (seg_bound),
        .res   (calc_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '{fault: FLT_NONE, addr: '0};
        end else begin
            if (accept) begin
                valid_q <= 1'b1;
                rsp_q   <= calc_res;
            end else if (rsp_ready) begin
                valid_q <= 1'b0;
            end
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_fault = rsp_q.fault;
    assign rsp_addr  = rsp_q.addr;

    // R7: an accepted request yields a response in the following cycle
    a_r7_resp_follows: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> rsp_valid);

    // R7: no new request is taken while a response is stalled
    a_r7_back_pressure: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |-> !req_ready);

    // R8: stalled response holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_fault) && $stable(rsp_addr));

    // R4: unused segment always faults with zero address
    a_r4_seg_fault: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_va[VA_W-1 -: SEG_W] == '0)
        |=> rsp_fault == 2'd1 && rsp_addr == '0);

    // R5: any faulted response carries a zero address
    a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_fault != 2'd0 |-> rsp_addr == '0);

endmodule

// File: tb/test_pte_addr_gen.sv
`timescale 1ns/1ps
module test_pte_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_addr;

    int  total = 0;
    int  bad   = 0;
    bit  chk_en = 1'b0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    pte_addr_gen i_pte_addr_gen (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_addr(rsp_addr)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_base  [4];
    logic [17:0] m_bound [4];
    bit          m_valid;
    logic [1:0]  m_fault;
    logic [31:0] m_addr;

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 0; m_fault = 0; m_addr = 0;
            for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_bound[i] = 0; end
        end else begin
            bit rdy;
            rdy = !m_valid || rsp_ready;
            if (m_valid && rsp_ready) m_valid = 0;
            if (req_valid && rdy) begin
                int s;
                int v;
                s = int'(req_va[31:30]);
                v = int'(req_va[29:12]);
                m_valid = 1;
                if (s == 0) begin m_fault = 1; m_addr = 0; end
                else if (v >= int'(m_bound[s])) begin m_fault = 2; m_addr = 0; end
                else begin m_fault = 0; m_addr = m_base[s] + 32'(v * 4); end
            end
            if (cfg_we && cfg_sel[1:0] != 0) begin
                if (cfg_sel[2]) m_bound[cfg_sel[1:0]] = cfg_data[17:0];
                else            m_base[cfg_sel[1:0]]  = cfg_data;
            end
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            string tg;
            chk("R7", "req_ready", 32'(req_ready), 32'(!m_valid || rsp_ready));
            chk("R7", "rsp_valid", 32'(rsp_valid), 32'(m_valid));
            if (m_valid) begin
                tg = (m_fault == 1) ? "R4" : (m_fault == 2) ? "R5" : "R3";
                chk(tg, "model fault", 32'(rsp_fault), 32'(m_fault));
                chk(tg, "model addr", rsp_addr, m_addr);
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_data = d;
        @(negedge clk); #2;
        cfg_we = 0;
    endtask

    task automatic req(input logic [31:0] va, input logic [1:0] ef, input logic [31:0] ea, input string tag);
        req_valid = 1; req_va = va;
        @(negedge clk);
        chk(tag, "valid", 32'(rsp_valid), 32'd1);
        chk(tag, "fault", 32'(rsp_fault), 32'(ef));
        chk(tag, "addr", rsp_addr, ea);
        #2 req_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "rsp_valid after reset", 32'(rsp_valid), 0);
        chk("R1", "req_ready after reset", 32'(req_ready), 1);
        chk_en = 1;
        #2;
        req(32'h4000_0000, 2'd2, 0, "R1");

        wr(3'b001, 32'h1000_0000);
        wr(3'b101, 32'd16);
        // R2 offset bits ignored
        req(32'h4000_5ABC, 2'd0, 32'h1000_0014, "R2");
        req(32'h4000_5000, 2'd0, 32'h1000_0014, "R2");
        // R5 edge of bound
        req(32'h4000_F000, 2'd0, 32'h1000_003C, "R5");
        req(32'h4001_0000, 2'd2, 0, "R5");
        // R4 / R6: segment 00 writes discarded, still faults
        wr(3'b000, 32'h1234_0000);
        wr(3'b100, 32'h0000_0100);
        req(32'h0000_3FFF, 2'd1, 0, "R4");
        req(32'h0000_0000, 2'd1, 0, "R6");
        // R6 bound takes low 18 bits only
        wr(3'b010, 32'h2000_0000);
        wr(3'b110, 32'hFFFC_0004);
        req(32'h8000_3000, 2'd0, 32'h2000_000C, "R6");
        req(32'h8000_4000, 2'd2, 0, "R6");
        // R3 wraparound
        wr(3'b011, 32'hFFFF_FFF0);
        wr(3'b111, 32'h0003_FFFF);
        req(32'hC000_5000, 2'd0, 32'h0000_0004, "R3");
        // R9 same-cycle write does not affect this request
        cfg_we = 1; cfg_sel = 3'b111; cfg_data = 0;
        req(32'hC000_5000, 2'd0, 32'h0000_0004, "R9");
        cfg_we = 0;
        req(32'hC000_5000, 2'd2, 0, "R9");
        wr(3'b111, 32'd20);
        // R8 stall holds response
        rsp_ready = 0;
        req(32'h4000_2000, 2'd0, 32'h1000_0008, "R8");
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R8", "held valid", 32'(rsp_valid), 1);
            chk("R8", "held addr", rsp_addr, 32'h1000_0008);
            chk("R8", "ready low", 32'(req_ready), 0);
            #2;
        end
        rsp_ready = 1;
        @(negedge clk);
        chk("R7", "drained", 32'(rsp_valid), 0);
        #2;

        // Randomised mix against the model
        for (int n = 0; n < 4000; n++) begin
            req_valid = ($urandom % 3) != 0;
            req_va    = {2'($urandom), 18'($urandom % 24), 12'($urandom)};
            rsp_ready = ($urandom % 4) != 0;
            cfg_we    = ($urandom % 12) == 0;
            cfg_sel   = 3'($urandom);
            cfg_data  = cfg_sel[2] ? 32'($urandom % 24) : $urandom;
            @(negedge clk); #2;
        end
        req_valid = 0; cfg_we = 0; rsp_ready = 1;
        repeat (3) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule